// File: doc/BRIEF.md
# Multi-Context 16-to-8 Routing Crossbar

This block routes signals between two neighbouring logic subarrays. It takes the sixteen outputs of a 4×4 subarray and drives eight non-local input lines on one side of the adjacent subarray. Each of the eight outputs picks one of the sixteen inputs through a 4-bit select field.

The select fields for all eight outputs form one 32-bit word. Four such words, one for each context, are held in a small configuration store. A 2-bit context identifier, shared across the whole array, chooses which word steers the multiplexers. The routing is purely combinational from the inputs and the identifier, so the whole pattern can change on every cycle.

A synchronous programming port writes and reads the stored words while the crossbar keeps routing. The port refuses a write to the context that is currently active, so the live routing is never disturbed by a load.

Top module: `ctx_xbar`

## Requirements
- R1: While rst_ni is low, and after it rises until the first write, all four context words are zero. Every output then follows src_i[0], and prog_rdata_o is zero.
- R2: Output dst_o[k] equals src_i[s] in the same cycle, with no register in the path. Here s is bits [4k+3:4k] of the active context word, read as an unsigned input index.
- R3: ctx_i selects context word ctx_i as the active word. A change of ctx_i changes the routing in the same cycle, with no other action needed.
- R4: When prog_we_i is high at a rising clock edge and prog_addr_i differs from ctx_i, prog_wdata_i is stored into context word prog_addr_i.
- R5: When prog_we_i is high at a rising clock edge and prog_addr_i equals ctx_i, the write is ignored. The stored word stays unchanged, and so does the routing that depends on it.
- R6: When prog_re_i is high at a rising clock edge, prog_rdata_o takes the word stored at prog_addr_i. The value is the one held before any write at that same edge.
- R7: When prog_re_i is low at a rising clock edge, prog_rdata_o holds its value.
- R8: When prog_we_i is low at a rising clock edge, no context word changes.
- R9: A write to a non-active context leaves the outputs of the active context unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the programming port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctx_i | input | 2 | Active context identifier |
| src_i | input | 16 | Outputs of the source subarray |
| dst_o | output | 8 | Non-local lines to the neighbouring subarray |
| prog_we_i | input | 1 | Write strobe for a context word |
| prog_re_i | input | 1 | Read strobe for a context word |
| prog_addr_i | input | 2 | Context word addressed by the programming port |
| prog_wdata_i | input | 32 | Word to write, 4 bits per output, output k at bits [4k+3:4k] |
| prog_rdata_o | output | 32 | Registered read-back word |

## Verification
Directed phases load a distinct pattern into each context: one output per input index, reversed and repeated selects, and a mix where several outputs share one input. Walking-one and walking-zero values on src_i then show each output picking exactly its selected input and no neighbour. Rapid changes of ctx_i across the loaded words show that the routing swaps in the cycle the identifier changes. Writes aimed at the active context, write and read at the same edge, and idle read strobes separate the guarded, ordered and held behaviours. A long random phase, compared with the reference model on every cycle, mixes all of these.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned XBAR_N_IN  = 16;
  localparam int unsigned XBAR_N_OUT = 8;
  localparam int unsigned XBAR_N_CTX = 4;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store #(
  parameter int unsigned N_CTX  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CTX_W = (N_CTX <= 1) ? 1 : $clog2(N_CTX)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CTX_W-1:0]        act_ctx_i,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [CTX_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  output logic [N_CTX*WORD_W-1:0] words_o
);
  logic [WORD_W-1:0] word_q [N_CTX];
  logic              wr_ok;

  // writes to the live context are refused
  assign wr_ok = we_i && (addr_i != act_ctx_i);

  for (genvar c = 0; c < N_CTX; c++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[c] <= '0;
      end else if (wr_ok && (addr_i == CTX_W'(c))) begin
        word_q[c] <= wdata_i;
      end
    end
    assign words_o[c*WORD_W +: WORD_W] = word_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (re_i) begin
      rdata_o <= word_q[addr_i];
    end
  end
endmodule

// File: rtl/xbar_word_pick.sv
module xbar_word_pick #(
  parameter int unsigned N_CTX  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CTX_W = (N_CTX <= 1) ? 1 : $clog2(N_CTX)
) (
  input  logic [N_CTX*WORD_W-1:0] words_i,
  input  logic [CTX_W-1:0]        ctx_i,
  output logic [WORD_W-1:0]       word_o
);
  always_comb begin
    word_o = '0;
    for (int c = 0; c < N_CTX; c++) begin
      if (ctx_i == CTX_W'(c)) word_o = words_i[c*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
  parameter int unsigned N_IN   = 16,
  localparam int unsigned SEL_W = (N_IN <= 1) ? 1 : $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             y_o
);
  always_comb begin
    y_o = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel_i == SEL_W'(i)) y_o = src_i[i];
    end
  end
endmodule

// File: rtl/ctx_xbar.sv
module ctx_xbar #(
  parameter int unsigned N_IN  = xbar_pkg::XBAR_N_IN,
  parameter int unsigned N_OUT = xbar_pkg::XBAR_N_OUT,
  parameter int unsigned N_CTX = xbar_pkg::XBAR_N_CTX,
  localparam int unsigned SEL_W  = xbar_pkg::idx_w(N_IN),
  localparam int unsigned CTX_W  = xbar_pkg::idx_w(N_CTX),
  localparam int unsigned WORD_W = N_OUT * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [N_IN-1:0]   src_i,
  output logic [N_OUT-1:0]  dst_o,
  input  logic              prog_we_i,
  input  logic              prog_re_i,
  input  logic [CTX_W-1:0]  prog_addr_i,
  input  logic [WORD_W-1:0] prog_wdata_i,
  output logic [WORD_W-1:0] prog_rdata_o
);
  logic [N_CTX*WORD_W-1:0] cfg_flat;
  logic [WORD_W-1:0]       act_word;

  xbar_cfg_store #(.N_CTX(N_CTX), .WORD_W(WORD_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_ctx_i(ctx_i),
    .we_i     (prog_we_i),
    .re_i     (prog_re_i),
    .addr_i   (prog_addr_i),
    .wdata_i  (prog_wdata_i),
    .rdata_o  (prog_rdata_o),
    .words_o  (cfg_flat)
  );

  xbar_word_pick #(.N_CTX(N_CTX), .WORD_W(WORD_W)) u_pick (
    .words_i(cfg_flat),
    .ctx_i  (ctx_i),
    .word_o (act_word)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    xbar_out_mux #(.N_IN(N_IN)) u_mux (
      .src_i(src_i),
      .sel_i(act_word[k*SEL_W +: SEL_W]),
      .y_o  (dst_o[k])
    );
  end
endmodule

// File: rtl/ctx_xbar_chk.sv
module ctx_xbar_chk #(
  parameter int unsigned N_IN   = 16,
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_CTX  = 4,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned CTX_W  = 2,
  parameter int unsigned WORD_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [CTX_W-1:0]        ctx_i,
  input logic [N_IN-1:0]         src_i,
  input logic [N_OUT-1:0]        dst_o,
  input logic                    prog_we_i,
  input logic                    prog_re_i,
  input logic [CTX_W-1:0]        prog_addr_i,
  input logic [WORD_W-1:0]       prog_wdata_i,
  input logic [WORD_W-1:0]       prog_rdata_o,
  input logic [N_CTX*WORD_W-1:0] cfg_flat
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_route
    AST_ROUTE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dst_o[k] == src_i[cfg_flat[int'(ctx_i)*WORD_W + k*SEL_W +: SEL_W]]); // R2
  end

  AST_WR_IDLE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_i && prog_addr_i != ctx_i) |=>
      cfg_flat[int'($past(prog_addr_i))*WORD_W +: WORD_W] == $past(prog_wdata_i)); // R4

  AST_WR_ACTIVE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_i && prog_addr_i == ctx_i) |=> $stable(cfg_flat)); // R5

  AST_RD_OLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_re_i |=>
      prog_rdata_o == $past(cfg_flat[int'(prog_addr_i)*WORD_W +: WORD_W])); // R6

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_re_i |=> $stable(prog_rdata_o)); // R7

  AST_NO_WE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_we_i |=> $stable(cfg_flat)); // R8
endmodule

bind ctx_xbar ctx_xbar_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_CTX(N_CTX),
  .SEL_W(SEL_W), .CTX_W(CTX_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctx_i       (ctx_i),
  .src_i       (src_i),
  .dst_o       (dst_o),
  .prog_we_i   (prog_we_i),
  .prog_re_i   (prog_re_i),
  .prog_addr_i (prog_addr_i),
  .prog_wdata_i(prog_wdata_i),
  .prog_rdata_o(prog_rdata_o),
  .cfg_flat    (cfg_flat)
);

// File: tb/ctx_xbar_tb.sv
`timescale 1ns/100ps
module ctx_xbar_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ctx_i = '0;
  logic [15:0] src_i = '0;
  logic [7:0]  dst_o;
  logic        prog_we_i = 1'b0;
  logic        prog_re_i = 1'b0;
  logic [1:0]  prog_addr_i = '0;
  logic [31:0] prog_wdata_i = '0;
  logic [31:0] prog_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ref_mem [4];
  logic [31:0] ref_rd;

  always #2 clk_i = ~clk_i;

  ctx_xbar u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctx_i(ctx_i), .src_i(src_i),
    .dst_o(dst_o), .prog_we_i(prog_we_i), .prog_re_i(prog_re_i),
    .prog_addr_i(prog_addr_i), .prog_wdata_i(prog_wdata_i),
    .prog_rdata_o(prog_rdata_o)
  );

  function automatic logic [7:0] ref_route(logic [31:0] w, logic [15:0] s);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = s[w[4*k +: 4]];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare mid-low phase, then advance the model over the edge
  task automatic step(string tag, logic [1:0] c, logic [15:0] s, logic we,
                      logic re, logic [1:0] a, logic [31:0] wd);
    @(negedge clk_i);
    ctx_i = c; src_i = s; prog_we_i = we; prog_re_i = re;
    prog_addr_i = a; prog_wdata_i = wd;
    #0.5;
    check({tag, " route"}, {24'h0, dst_o}, {24'h0, ref_route(ref_mem[c], s)});
    check({tag, " rdata"}, prog_rdata_o, ref_rd);
    @(posedge clk_i);
    if (re) ref_rd = ref_mem[a];
    if (we && a != c) ref_mem[a] = wd;
  endtask

  task automatic readback(string tag, logic [1:0] c, logic [1:0] a);
    step(tag, c, 16'h0, 1'b0, 1'b1, a, 32'h0);
    step(tag, c, 16'h0, 1'b0, 1'b0, a, 32'h0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) ref_mem[c] = '0;
    ref_rd = '0;
    // R1: reset state
    src_i = 16'h0001;
    #5;
    check("R1 reset route src0=1", {24'h0, dst_o}, 32'hff);
    check("R1 reset rdata", prog_rdata_o, 32'h0);
    src_i = 16'hfffe;
    #1;
    check("R1 reset route src0=0", {24'h0, dst_o}, 32'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int c = 0; c < 4; c++) readback("R1 zero after reset", 2'd0, 2'(c));

    // R4: load three idle contexts while context 0 is active
    step("R4 load ctx1", 2'd0, 16'h1234, 1'b1, 1'b0, 2'd1, 32'h76543210);
    step("R4 load ctx2", 2'd0, 16'h8001, 1'b1, 1'b0, 2'd2, 32'h89abcdef);
    step("R4 load ctx3", 2'd0, 16'h00ff, 1'b1, 1'b0, 2'd3, 32'h5555f0f0);
    // R4/R9: load ctx0 from ctx1, routing of ctx1 must not move
    step("R9 write idle ctx0", 2'd1, 16'h00f0, 1'b1, 1'b0, 2'd0, 32'h31313131);
    step("R9 after write", 2'd1, 16'h00f0, 1'b0, 1'b0, 2'd0, 32'h0);
    for (int c = 0; c < 4; c++) readback("R4 readback", 2'd1, 2'(c));

    // R2: walking one and walking zero through each context
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 16; i++) begin
        step("R2 walk1", 2'(c), 16'(1) << i, 1'b0, 1'b0, 2'd0, 32'h0);
        step("R2 walk0", 2'(c), ~(16'(1) << i), 1'b0, 1'b0, 2'd0, 32'h0);
      end
    end

    // R3: context swaps every cycle with a fixed input
    for (int n = 0; n < 16; n++)
      step("R3 swap", 2'(n % 4), 16'ha5c3, 1'b0, 1'b0, 2'd0, 32'h0);
    step("R3 swap back", 2'd2, 16'h0180, 1'b0, 1'b0, 2'd0, 32'h0);
    step("R3 swap fwd", 2'd3, 16'h0180, 1'b0, 1'b0, 2'd0, 32'h0);

    // R5: write to the active context is refused
    step("R5 write active", 2'd2, 16'hf00f, 1'b1, 1'b0, 2'd2, 32'hffffffff);
    step("R5 route kept", 2'd2, 16'hf00f, 1'b0, 1'b0, 2'd0, 32'h0);
    readback("R5 word kept", 2'd3, 2'd2);
    check("R5 explicit word", prog_rdata_o, 32'h89abcdef);

    // R6: read and write same address at one edge returns old word
    step("R6 rd+wr same", 2'd0, 16'h0, 1'b1, 1'b1, 2'd3, 32'h0badf00d);
    step("R6 old value", 2'd0, 16'h0, 1'b0, 1'b0, 2'd3, 32'h0);
    check("R6 explicit old", prog_rdata_o, 32'h5555f0f0);
    readback("R6 new value", 2'd0, 2'd3);
    check("R6 explicit new", prog_rdata_o, 32'h0badf00d);

    // R7: rdata holds while read strobe low, R8: no write without strobe
    for (int n = 0; n < 4; n++)
      step("R7 hold", 2'(n), 16'h1111, 1'b0, 1'b0, 2'(3 - n), 32'hdeadbeef);
    check("R7 explicit hold", prog_rdata_o, 32'h0badf00d);
    for (int c = 0; c < 4; c++) readback("R8 no stray write", 2'd0, 2'(c));

    // random mix of all behaviours
    for (int n = 0; n < 3000; n++)
      step("R2 R4 R5 R6 random", 2'($urandom), 16'($urandom),
           1'($urandom % 3 == 0), 1'($urandom), 2'($urandom), $urandom);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule